// File: doc/BRIEF.md
# Receive Queue Status and Event Interrupt Block

This block holds completed-packet pointers for a small set of receive queues. A producer pushes a pointer into a chosen queue when a packet finishes. A host pops pointers back out, one per request, and the oldest pointer comes first. Each queue drives its own level-sensitive line that is high for as long as the queue holds at least one pointer. Other agents can watch these lines without polling.

Each queue raises an up event when it goes from empty to non-empty, and a down event when a pop drains it. A software-written routing table sends each queue's events to one bit of an interrupt status register. An up event sets that bit and a down event clears it. The interrupt output is high while any status bit is both set and enabled by a software-written enable mask. Because a bit clears when its queue drains, software never has to acknowledge it.

Software reaches the routing table, the enable mask and the status register through a simple register port. Writes take effect at the clock edge. Reads are combinational from the current address.

Top module: `rxq_event_irq`

## Requirements
- R1: A pop request returns, in the same cycle, the oldest pointer still held in the selected queue, and removes it at the clock edge. Pointers leave each queue in the order they were pushed.
- R2: The status line `q_nonempty[q]` is high exactly when queue q holds at least one pointer. It changes one cycle after the push or pop that changes the occupancy.
- R3: A push into an empty queue produces an up event. A push into a non-empty queue produces no event. An up event from a queue whose routing entry is valid sets the status bit that the entry selects.
- R4: A pop that leaves its queue empty produces a down event. A down event from a queue whose routing entry is valid clears the status bit that the entry selects.
- R5: When a push and a pop target the same queue in the same cycle, the occupancy stays the same and neither event is produced. If that queue is empty, the pushed pointer passes straight through to `pop_ptr` and `pop_err` stays low.
- R6: A pop of an empty queue with no push to that queue in the same cycle returns `pop_ptr` = 0 with `pop_err` = 1. It changes no occupancy, no status line and no status bit.
- R7: Each queue holds at most DEPTH pointers. A push into a full queue with no pop to that queue in the same cycle is discarded, and the stored contents stay intact.
- R8: Register addresses 0 to NUM_Q-1 hold the routing entry of the queue with that number: bit 7 marks the entry valid, and bits [2:0] give the status bit index. A queue whose entry is not valid changes no status bit. Every entry reads back as written.
- R9: Address NUM_Q (4) holds the enable mask and address NUM_Q+1 (5) reads the status register. `irq` is high exactly when the status AND the mask is nonzero. Other addresses read as 0.
- R10: After reset, all queues are empty, all status lines are low, the routing entries are invalid, the mask and the status are 0, and `irq` is low.
- R11: If, in one cycle, one queue's up event and another queue's down event map to the same status bit, that bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push_valid | input | 1 | Push a pointer this cycle |
| push_qid | input | 2 | Queue selected for the push |
| push_ptr | input | 16 | Pointer to store |
| pop_req | input | 1 | Pop a pointer this cycle |
| pop_qid | input | 2 | Queue selected for the pop |
| pop_ptr | output | 16 | Popped pointer, or 0 on error |
| pop_err | output | 1 | The pop targeted an empty queue |
| q_nonempty | output | 4 | Per-queue level status line |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt: any enabled status bit set |

## Verification
The assertions assume that the queue and register inputs are stable and known around each rising edge. They also assume that queue indices stay below NUM_Q, so that every pop outcome and every level change can be traced to a push or pop in the cycle before. The stimulus drives every input on the falling edge. It draws queue numbers only from the implemented range and register addresses only from 0 to 5. It writes routing entries with indices below the status width, so each event has a defined target bit. Random routing and mask rewrites are mixed in, so that some queues stay unmapped and some share a bit for long stretches.

// File: rtl/qsia_pkg.sv
// Package: constants shared by the queue status and event interrupt block.
// Assumes a register data path of 8 bits; status width must not exceed it.
package qsia_pkg;
    localparam int REG_DW        = 8;  // register data width
    localparam int MAP_VALID_BIT = 7;  // routing entry valid flag position
endpackage

// File: rtl/rxq_fifo.sv
// Module: one pointer queue with occupancy tracking and edge events.
// Assumes push and pop are single-cycle strobes; DEPTH >= 2.
// A push and a pop in the same cycle keep the count; on an empty queue
// the pushed pointer is presented on head and nothing is stored.
module rxq_fifo #(
    parameter int PTR_W = 16,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [PTR_W-1:0] push_ptr,
    input  logic             pop,
    output logic [PTR_W-1:0] head,
    output logic             nonempty,
    output logic             up_evt,
    output logic             dn_evt
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DEPTH - 1);

    logic [PTR_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [CNT_W-1:0] cnt;
    logic             empty, full, do_wr, do_rd;

    assign empty  = (cnt == '0);
    assign full   = (cnt == CNT_MAX);
    // store when there is room, or when a pop frees the head slot
    assign do_wr  = push && (pop ? !empty : !full);
    assign do_rd  = pop && !empty;

    function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] i);
        return (i == IDX_LAST) ? '0 : i + 1'b1;
    endfunction

    // storage array, no reset needed
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_idx] <= push_ptr;
    end

    // read/write indices and occupancy count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx <= '0;
            rd_idx <= '0;
            cnt    <= '0;
        end else begin
            if (do_wr) wr_idx <= next_idx(wr_idx);
            if (do_rd) rd_idx <= next_idx(rd_idx);
            case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // head output, pass-through when empty
    always_comb head = empty ? push_ptr : mem[rd_idx];

    assign nonempty = !empty;
    assign up_evt   = push && !pop && empty;
    assign dn_evt   = pop && !push && (cnt == CNT_W'(1));
endmodule

// File: rtl/rxq_irq_map.sv
// Module: routing table, enable mask and status register driven by events.
// Assumes NUM_BITS <= 8 and NUM_BITS >= 2. Events use the routing entry
// as it was before any write in the same cycle. Set beats clear on a bit.
module rxq_irq_map
    import qsia_pkg::*;
#(
    parameter int NUM_Q    = 4,
    parameter int NUM_BITS = 8,
    parameter int ADDR_W   = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  logic [REG_DW-1:0]      cfg_wdata,
    input  logic [NUM_Q-1:0]       up_evt,
    input  logic [NUM_Q-1:0]       dn_evt,
    output logic [REG_DW-1:0]      cfg_rdata,
    output logic [NUM_BITS-1:0]    status,
    output logic [NUM_BITS-1:0]    mask,
    output logic [NUM_Q-1:0]       map_vld,
    output logic [NUM_Q*$clog2(NUM_BITS)-1:0] map_idx,
    output logic                   irq
);
    localparam int IDX_W = $clog2(NUM_BITS);
    localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(NUM_Q);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_Q + 1);

    logic [NUM_BITS-1:0] set_v, clr_v;

    // one routing entry per queue
    for (genvar q = 0; q < NUM_Q; q++) begin : g_entry
        // write the entry when its own address is selected
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                map_vld[q]                   <= 1'b0;
                map_idx[q*IDX_W +: IDX_W]    <= '0;
            end else if (cfg_wr && cfg_addr == ADDR_W'(q)) begin
                map_vld[q]                   <= cfg_wdata[MAP_VALID_BIT];
                map_idx[q*IDX_W +: IDX_W]    <= cfg_wdata[IDX_W-1:0];
            end
        end
    end

    // collect set and clear requests from routed events
    always_comb begin
        set_v = '0;
        clr_v = '0;
        for (int q = 0; q < NUM_Q; q++) begin
            if (map_vld[q] && up_evt[q]) set_v[map_idx[q*IDX_W +: IDX_W]] = 1'b1;
            if (map_vld[q] && dn_evt[q]) clr_v[map_idx[q*IDX_W +: IDX_W]] = 1'b1;
        end
    end

    // mask and status registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask   <= '0;
            status <= '0;
        end else begin
            if (cfg_wr && cfg_addr == MASK_ADDR) mask <= cfg_wdata[NUM_BITS-1:0];
            status <= (status & ~clr_v) | set_v;
        end
    end

    // combinational register read mux
    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == MASK_ADDR) begin
            cfg_rdata = REG_DW'(mask);
        end else if (cfg_addr == STAT_ADDR) begin
            cfg_rdata = REG_DW'(status);
        end else begin
            for (int q = 0; q < NUM_Q; q++) begin
                if (cfg_addr == ADDR_W'(q)) begin
                    cfg_rdata[MAP_VALID_BIT] = map_vld[q];
                    cfg_rdata[IDX_W-1:0]     = map_idx[q*IDX_W +: IDX_W];
                end
            end
        end
    end

    assign irq = |(status & mask);
endmodule

// File: rtl/rxq_event_irq.sv
// Module: top of the receive queue status and event interrupt block.
// Assumes push_qid/pop_qid < NUM_Q. One push and one pop port, each of
// which may target any queue; both may target the same queue.
module rxq_event_irq
    import qsia_pkg::*;
#(
    parameter int NUM_Q    = 4,
    parameter int PTR_W    = 16,
    parameter int DEPTH    = 4,
    parameter int NUM_BITS = 8,
    localparam int QID_W   = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    localparam int ADDR_W  = $clog2(NUM_Q + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [QID_W-1:0]  push_qid,
    input  logic [PTR_W-1:0]  push_ptr,
    input  logic              pop_req,
    input  logic [QID_W-1:0]  pop_qid,
    output logic [PTR_W-1:0]  pop_ptr,
    output logic              pop_err,
    output logic [NUM_Q-1:0]  q_nonempty,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              irq
);
    localparam int IDX_W = $clog2(NUM_BITS);

    logic [NUM_Q-1:0]       push_sel, pop_sel, up_evt, dn_evt;
    logic [PTR_W-1:0]       head [NUM_Q];
    logic [NUM_BITS-1:0]    status_q, mask_q;
    logic [NUM_Q-1:0]       map_vld;
    logic [NUM_Q*IDX_W-1:0] map_idx;
    logic                   same_q;

    // one queue per index, each with its own push/pop decode
    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        assign push_sel[q] = push_valid && push_qid == QID_W'(q);
        assign pop_sel[q]  = pop_req    && pop_qid  == QID_W'(q);

        rxq_fifo #(.PTR_W(PTR_W), .DEPTH(DEPTH)) i_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (push_sel[q]),
            .push_ptr (push_ptr),
            .pop      (pop_sel[q]),
            .head     (head[q]),
            .nonempty (q_nonempty[q]),
            .up_evt   (up_evt[q]),
            .dn_evt   (dn_evt[q])
        );
    end

    // pop result: error when the queue is empty and nothing passes through
    always_comb begin
        same_q  = push_valid && (push_qid == pop_qid);
        pop_err = pop_req && !q_nonempty[pop_qid] && !same_q;
        pop_ptr = (pop_req && !pop_err) ? head[pop_qid] : '0;
    end

    rxq_irq_map #(.NUM_Q(NUM_Q), .NUM_BITS(NUM_BITS), .ADDR_W(ADDR_W)) i_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (reg_wr),
        .cfg_addr  (reg_addr),
        .cfg_wdata (reg_wdata),
        .up_evt    (up_evt),
        .dn_evt    (dn_evt),
        .cfg_rdata (reg_rdata),
        .status    (status_q),
        .mask      (mask_q),
        .map_vld   (map_vld),
        .map_idx   (map_idx),
        .irq       (irq)
    );
endmodule

// File: rtl/rxq_event_irq_chk.sv
// Checker: temporal properties of the queue status and event block.
// Assumes queue indices on the ports are below NUM_Q.
module rxq_event_irq_chk #(
    parameter int NUM_Q    = 4,
    parameter int PTR_W    = 16,
    parameter int NUM_BITS = 8,
    parameter int QID_W    = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   push_valid,
    input logic [QID_W-1:0]       push_qid,
    input logic                   pop_req,
    input logic [QID_W-1:0]       pop_qid,
    input logic [PTR_W-1:0]       pop_ptr,
    input logic                   pop_err,
    input logic [NUM_Q-1:0]       q_nonempty,
    input logic [NUM_Q-1:0]       up_evt,
    input logic [NUM_Q-1:0]       dn_evt,
    input logic [NUM_BITS-1:0]    status_q,
    input logic [NUM_Q-1:0]       map_vld,
    input logic [NUM_Q*$clog2(NUM_BITS)-1:0] map_idx
);
    localparam int IDX_W = $clog2(NUM_BITS);

    // R6: empty pop without pass-through reports error with null pointer
    assert_pop_empty_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !q_nonempty[pop_qid] && !(push_valid && push_qid == pop_qid))
        |-> (pop_err && pop_ptr == '0));

    // R5: a queue never raises up and down events together
    assert_no_dual_evt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (up_evt & dn_evt) == '0);

    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        // R3: an up event leaves the queue non-empty
        assert_up_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
            up_evt[q] |=> q_nonempty[q]);

        // R4: a down event leaves the queue empty
        assert_dn_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
            dn_evt[q] |=> !q_nonempty[q]);

        // R3: a routed up event sets its status bit
        assert_up_sets_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (up_evt[q] && map_vld[q])
            |=> status_q[$past(map_idx[q*IDX_W +: IDX_W])]);

        // R2: the status line rises only after a push to that queue
        assert_rise_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(q_nonempty[q]) |-> $past(push_valid && push_qid == QID_W'(q)));

        // R2: the status line falls only after a pop from that queue
        assert_fall_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(q_nonempty[q]) |-> $past(pop_req && pop_qid == QID_W'(q)));
    end
endmodule

bind rxq_event_irq rxq_event_irq_chk #(
    .NUM_Q(NUM_Q), .PTR_W(PTR_W), .NUM_BITS(NUM_BITS), .QID_W(QID_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .push_qid   (push_qid),
    .pop_req    (pop_req),
    .pop_qid    (pop_qid),
    .pop_ptr    (pop_ptr),
    .pop_err    (pop_err),
    .q_nonempty (q_nonempty),
    .up_evt     (up_evt),
    .dn_evt     (dn_evt),
    .status_q   (status_q),
    .map_vld    (map_vld),
    .map_idx    (map_idx)
);

// File: tb/test_rxq_event_irq.sv
`timescale 1ns/1ps
// Bench: directed corner cases then seeded random traffic against a model.
module test_rxq_event_irq;
    localparam int NQ = 4;
    localparam int DP = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        push_valid, pop_req, reg_wr;
    logic [1:0]  push_qid, pop_qid;
    logic [15:0] push_ptr, pop_ptr;
    logic        pop_err, irq;
    logic [3:0]  q_nonempty;
    logic [2:0]  reg_addr;
    logic [7:0]  reg_wdata, reg_rdata;

    int nchk = 0;
    int nerr = 0;

    // bench model
    logic [15:0] mq [NQ][DP];
    int          mcnt [NQ];
    logic        mvld [NQ];
    logic [2:0]  midx [NQ];
    logic [7:0]  mmask, mstat;

    always #4 clk = ~clk;  // 125 MHz

    rxq_event_irq i_rxq_event_irq (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_qid(push_qid), .push_ptr(push_ptr),
        .pop_req(pop_req), .pop_qid(pop_qid), .pop_ptr(pop_ptr), .pop_err(pop_err),
        .q_nonempty(q_nonempty),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_read(input int a);
        if (a < NQ) return {mvld[a], 4'b0, midx[a]};
        if (a == NQ) return mmask;
        if (a == NQ + 1) return mstat;
        return 8'h00;
    endfunction

    // one cycle: drive, check outputs, advance the model
    task automatic step(input logic pv, input int pq, input logic [15:0] pp,
                        input logic rv, input int rq,
                        input logic wv, input int wa, input logic [7:0] wd, input int ra);
        logic [15:0] eptr;
        logic        eerr;
        logic [7:0]  setv, clrv;
        int          oc;
        @(negedge clk);
        push_valid = pv; push_qid = 2'(pq); push_ptr = pp;
        pop_req = rv; pop_qid = 2'(rq);
        reg_wr = wv; reg_addr = 3'(wv ? wa : ra); reg_wdata = wd;
        #1;
        for (int q = 0; q < NQ; q++) chk("R2", q_nonempty[q], mcnt[q] > 0);
        chk("R9", irq, |(mstat & mmask));
        if (!wv) chk("R8 R9", reg_rdata, exp_read(ra));
        if (rv) begin
            if (mcnt[rq] > 0) begin
                eptr = mq[rq][0]; eerr = 1'b0;
                chk("R1", pop_ptr, eptr);
            end else if (pv && pq == rq) begin
                eptr = pp; eerr = 1'b0;
                chk("R5", pop_ptr, eptr);
            end else begin
                eptr = 16'h0; eerr = 1'b1;
                chk("R6", pop_ptr, eptr);
            end
            chk(eerr ? "R6" : "R1", pop_err, eerr);
        end
        // events and status (R3 R4 R11: clear then set)
        setv = '0; clrv = '0;
        for (int q = 0; q < NQ; q++) begin
            logic pvq, rvq;
            pvq = pv && pq == q;
            rvq = rv && rq == q;
            if (mvld[q] && pvq && !rvq && mcnt[q] == 0) setv[midx[q]] = 1'b1;
            if (mvld[q] && rvq && !pvq && mcnt[q] == 1) clrv[midx[q]] = 1'b1;
        end
        mstat = (mstat & ~clrv) | setv;
        // queue contents (R1 R5 R7)
        for (int q = 0; q < NQ; q++) begin
            logic pvq, rvq;
            pvq = pv && pq == q;
            rvq = rv && rq == q;
            oc  = mcnt[q];
            if (rvq && oc > 0) begin
                for (int k = 0; k < DP - 1; k++) mq[q][k] = mq[q][k+1];
                mcnt[q]--;
            end
            if (pvq && !(rvq && oc == 0) && mcnt[q] < DP) begin
                mq[q][mcnt[q]] = pp;
                mcnt[q]++;
            end
        end
        if (wv) begin
            if (wa < NQ) begin mvld[wa] = wd[7]; midx[wa] = wd[2:0]; end
            else if (wa == NQ) mmask = wd;
        end
    endtask

    task automatic idle(input int ra);
        step(0, 0, 16'h0, 0, 0, 0, 0, 8'h0, ra);
    endtask

    // watchdog: counts as a failed check
    initial begin
        #(8 * 200000);
        nerr++; nchk++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int q = 0; q < NQ; q++) begin mcnt[q] = 0; mvld[q] = 0; midx[q] = 0; end
        mmask = 0; mstat = 0;
        push_valid = 0; pop_req = 0; reg_wr = 0; push_qid = 0; pop_qid = 0;
        push_ptr = 0; reg_addr = 0; reg_wdata = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        // R10: reset state of status, mask, routing entries
        idle(5); idle(4); idle(0); idle(3);
        // R8: route q0,q1 -> bit1, q2 -> bit4, q3 unmapped; R9 mask bit1 only
        step(0, 0, 0, 0, 0, 1, 0, 8'h81, 0);
        step(0, 0, 0, 0, 0, 1, 1, 8'h81, 0);
        step(0, 0, 0, 0, 0, 1, 2, 8'h84, 0);
        step(0, 0, 0, 0, 0, 1, 3, 8'h05, 0);
        step(0, 0, 0, 0, 0, 1, 4, 8'h02, 0);
        idle(0); idle(2); idle(3); idle(4);
        // R6: pop of empty queue
        step(0, 0, 0, 1, 0, 0, 0, 0, 5);
        idle(5);
        // R7: five pushes into q0 (one dropped), then five pops (last errors)
        for (int i = 0; i < 5; i++) step(1, 0, 16'h100 + 16'(i), 0, 0, 0, 0, 0, 5);
        for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 0, 0, 0, 0, 5);
        idle(5);
        // R5: pass-through on empty q2, then push+pop on non-empty q2
        step(1, 2, 16'hABCD, 1, 2, 0, 0, 0, 5);
        idle(5);
        step(1, 2, 16'h0202, 0, 0, 0, 0, 0, 5);
        step(1, 2, 16'h0203, 1, 2, 0, 0, 0, 5);
        step(0, 0, 0, 1, 2, 0, 0, 0, 5);
        idle(5);
        // R8: unmapped q3 events leave status alone
        step(1, 3, 16'h0303, 0, 0, 0, 0, 0, 5);
        step(0, 0, 0, 1, 3, 0, 0, 0, 5);
        idle(5);
        // R11: q0 drains while q1 fills, both routed to bit1
        step(1, 0, 16'h0001, 0, 0, 0, 0, 0, 5);
        step(1, 1, 16'h0011, 1, 0, 0, 0, 0, 5);
        idle(5);
        step(0, 0, 0, 1, 1, 0, 0, 0, 5);
        idle(5);
        // random traffic with occasional routing and mask rewrites
        for (int n = 0; n < 4000; n++) begin
            logic wv;
            int   wa;
            wv = ($urandom % 40) == 0;
            wa = $urandom % 5;
            step(($urandom % 2) == 0, $urandom % NQ, 16'($urandom),
                 ($urandom % 100) < 45, $urandom % NQ,
                 wv, wa,
                 (wa < NQ) ? {1'($urandom), 4'b0, 3'($urandom)} : 8'($urandom),
                 $urandom % 6);
        end
        idle(5);
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule